// File: doc/BRIEF.md
# Two-List Hot Data Identifier

This block sorts logical block addresses into hot and cold for a flash translation layer. It keeps two short recency-ordered lists in registers. The candidate list holds addresses that have been written once recently. The hot list holds addresses that have been written again while they were still candidates. Every stored entry is compared in parallel with an incoming address, so one write is classified and applied in each clock cycle.

Write requests are the only traffic that changes the lists. A separate query port lets the garbage collector ask whether an address is hot, so that it can leave hot live pages where they are instead of relocating them. The query answer is registered. It reflects the lists as they stood in the cycle the query was issued, before any write in that same cycle is applied. An address evicted from the hot list is not discarded: it drops back to the front of the candidate list, where a single further write makes it hot again.

Top module: `hot_data_ident`

## Requirements
- R1: After reset both lists are empty, every query reports cold, and `qry_vld_o` and `qry_hot_o` are 0 while reset is asserted.
- R2: A write (`wr_valid_i`=1) of an address found in neither list places it at the most recent position of the candidate list, and the address still queries cold.
- R3: A write of an address held in the candidate list removes it from that list and places it at the most recent position of the hot list, so it queries hot from the next cycle on.
- R4: A write of an address already in the hot list moves it to the hot list's most recent position. When the hot list is full and another address is promoted, the least recently written hot entry is the one that leaves.
- R5: The hot list holds HOT_DEPTH (default 4) entries. An entry pushed out of a full hot list becomes the most recent candidate and queries cold, and it outlasts 7 further new candidate inserts, so one more write then makes it hot.
- R6: The candidate list holds CAND_DEPTH (default 8) entries. A new address inserted into a full candidate list drops the least recent candidate, and a later write of the dropped address makes it a candidate again, not hot.
- R7: A query issued in the same cycle as a write returns the classification from before that write.
- R8: `qry_vld_o` is 1 exactly in the cycle after a cycle with `qry_valid_i`=1 and 0 otherwise. `qry_hot_o` is 1 when the queried address was in the hot list, and 0 when it was not.
- R9: A cycle with `wr_valid_i`=0 changes neither list, whatever `wr_addr_i` holds.
- R10: Promoting a candidate while the hot list is not full leaves a free candidate slot. Older candidates then move up, so one extra new address can be inserted before the oldest candidate is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | A write to `wr_addr_i` happens this cycle |
| wr_addr_i | input | ADDR_W | Logical block address being written |
| qry_valid_i | input | 1 | Hot-status query for `qry_addr_i` this cycle |
| qry_addr_i | input | ADDR_W | Logical block address being queried |
| qry_vld_o | output | 1 | Query answer valid, one cycle after the query |
| qry_hot_o | output | 1 | Queried address was hot |

## Verification
Errors in the list state appear at the query port only after a delay, and only through ordering. A wrong recency order is invisible until a full list has to evict. It then shows up as the wrong address turning cold after a promotion, or a dropped candidate that still turns hot after one write. For that reason the directed sequences fill each list exactly to capacity and then probe the entries at the boundary. A scoreboard model of both lists covers the long mixed traffic, so a state corruption is reported at the first later query that touches the damaged entry.

// File: rtl/hdi_pkg.sv
package hdi_pkg;

  typedef struct packed {
    logic ins;  // push an address in at the most recent slot
    logic del;  // remove the entry at the given index
  } list_cmd_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_HOT,
    WR_CAND,
    WR_NEW
  } wr_kind_e;

endpackage

// File: rtl/hdi_lru_list.sv
module hdi_lru_list
  import hdi_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  list_cmd_t         cmd_i,
  input  logic [IDX_W-1:0]  del_idx_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic              wr_hit_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              qry_hit_o,
  output logic              full_o,
  output logic [ADDR_W-1:0] lru_addr_o,
  output logic              mru_vld_o,
  output logic [ADDR_W-1:0] mru_addr_o
);

  // slot 0 is most recent, slot DEPTH-1 least recent; valid slots are packed from 0
  logic [ADDR_W-1:0] ent_q  [DEPTH];
  logic [ADDR_W-1:0] ent_d  [DEPTH];
  logic [ADDR_W-1:0] up_ent [DEPTH];
  logic [ADDR_W-1:0] dn_ent [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d, up_vld, dn_vld;
  logic [DEPTH-1:0]  shr_vec, shl_vec;
  logic [DEPTH-1:0]  wr_hit_vec, qry_hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign wr_hit_vec[g]  = vld_q[g] && (ent_q[g] == wr_addr_i);
    assign qry_hit_vec[g] = vld_q[g] && (ent_q[g] == qry_addr_i);

    if (g == 0) begin : g_head
      assign up_ent[g] = ins_addr_i;
      assign up_vld[g] = 1'b1;
    end else begin : g_body_up
      assign up_ent[g] = ent_q[g-1];
      assign up_vld[g] = vld_q[g-1];
    end

    if (g == DEPTH - 1) begin : g_tail
      assign dn_ent[g] = '0;
      assign dn_vld[g] = 1'b0;
    end else begin : g_body_dn
      assign dn_ent[g] = ent_q[g+1];
      assign dn_vld[g] = vld_q[g+1];
    end

    // insert shifts toward the tail up to the removed slot (or through the whole list)
    assign shr_vec[g] = cmd_i.ins && (!cmd_i.del || (IDX_W'(g) <= del_idx_i));
    // delete without insert closes the gap from the tail side
    assign shl_vec[g] = !cmd_i.ins && cmd_i.del && (IDX_W'(g) >= del_idx_i);

    assign ent_d[g] = shr_vec[g] ? up_ent[g] : shl_vec[g] ? dn_ent[g] : ent_q[g];
    assign vld_d[g] = shr_vec[g] ? up_vld[g] : shl_vec[g] ? dn_vld[g] : vld_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  always_comb begin
    wr_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_hit_vec[i]) wr_idx_o = wr_idx_o | IDX_W'(i);
    end
  end

  assign wr_hit_o   = |wr_hit_vec;
  assign qry_hit_o  = |qry_hit_vec;
  assign full_o     = vld_q[DEPTH-1];
  assign lru_addr_o = ent_q[DEPTH-1];
  assign mru_vld_o  = vld_q[0];
  assign mru_addr_o = ent_q[0];

  assert_packed_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q & (vld_q + DEPTH'(1))) == '0);

  assert_unique_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit_vec) && $onehot0(qry_hit_vec));

  assert_evict_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.ins && !cmd_i.del && full_o) |=> (full_o && lru_addr_o == $past(ent_q[DEPTH-2])));

  assert_gap_close_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i.ins && cmd_i.del) |=> !full_o);

endmodule

// File: rtl/hdi_wr_ctrl.sv
module hdi_wr_ctrl
  import hdi_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned HOT_IDX_W  = 2,
  parameter int unsigned CAND_IDX_W = 3
) (
  input  logic                  wr_valid_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic                  hot_hit_i,
  input  logic [HOT_IDX_W-1:0]  hot_idx_i,
  input  logic                  hot_full_i,
  input  logic [ADDR_W-1:0]     hot_lru_i,
  input  logic                  cand_hit_i,
  input  logic [CAND_IDX_W-1:0] cand_idx_i,
  output wr_kind_e              kind_o,
  output list_cmd_t             hot_cmd_o,
  output logic [HOT_IDX_W-1:0]  hot_del_idx_o,
  output list_cmd_t             cand_cmd_o,
  output logic [CAND_IDX_W-1:0] cand_del_idx_o,
  output logic [ADDR_W-1:0]     cand_ins_addr_o
);

  always_comb begin
    if (!wr_valid_i)     kind_o = WR_IDLE;
    else if (hot_hit_i)  kind_o = WR_HOT;
    else if (cand_hit_i) kind_o = WR_CAND;
    else                 kind_o = WR_NEW;
  end

  always_comb begin
    hot_cmd_o       = '0;
    cand_cmd_o      = '0;
    hot_del_idx_o   = hot_idx_i;
    cand_del_idx_o  = cand_idx_i;
    cand_ins_addr_o = wr_addr_i;
    unique case (kind_o)
      WR_HOT: begin
        hot_cmd_o = '{ins: 1'b1, del: 1'b1};
      end
      WR_CAND: begin
        hot_cmd_o       = '{ins: 1'b1, del: 1'b0};
        // demoted hot entry refills the candidate slot being vacated
        cand_cmd_o      = '{ins: hot_full_i, del: 1'b1};
        cand_ins_addr_o = hot_lru_i;
      end
      WR_NEW: begin
        cand_cmd_o = '{ins: 1'b1, del: 1'b0};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hot_data_ident.sv
module hot_data_ident
  import hdi_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned HOT_DEPTH  = 4,
  parameter int unsigned CAND_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              qry_valid_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic              qry_vld_o,
  output logic              qry_hot_o
);

  localparam int unsigned HOT_IDX_W  = (HOT_DEPTH > 1) ? $clog2(HOT_DEPTH) : 1;
  localparam int unsigned CAND_IDX_W = (CAND_DEPTH > 1) ? $clog2(CAND_DEPTH) : 1;

  wr_kind_e              kind;
  list_cmd_t             hot_cmd, cand_cmd;
  logic [HOT_IDX_W-1:0]  hot_del_idx, hot_wr_idx;
  logic [CAND_IDX_W-1:0] cand_del_idx, cand_wr_idx;
  logic [ADDR_W-1:0]     cand_ins_addr;
  logic                  hot_wr_hit, hot_qry_hit, hot_full, hot_mru_vld;
  logic [ADDR_W-1:0]     hot_lru, hot_mru;
  logic                  cand_wr_hit, cand_qry_hit, cand_full, cand_mru_vld;
  logic [ADDR_W-1:0]     cand_lru, cand_mru;
  logic                  qry_vld_q, qry_hot_q;

  hdi_wr_ctrl #(
    .ADDR_W    (ADDR_W),
    .HOT_IDX_W (HOT_IDX_W),
    .CAND_IDX_W(CAND_IDX_W)
  ) u_ctrl (
    .wr_valid_i     (wr_valid_i),
    .wr_addr_i      (wr_addr_i),
    .hot_hit_i      (hot_wr_hit),
    .hot_idx_i      (hot_wr_idx),
    .hot_full_i     (hot_full),
    .hot_lru_i      (hot_lru),
    .cand_hit_i     (cand_wr_hit),
    .cand_idx_i     (cand_wr_idx),
    .kind_o         (kind),
    .hot_cmd_o      (hot_cmd),
    .hot_del_idx_o  (hot_del_idx),
    .cand_cmd_o     (cand_cmd),
    .cand_del_idx_o (cand_del_idx),
    .cand_ins_addr_o(cand_ins_addr)
  );

  hdi_lru_list #(
    .DEPTH (HOT_DEPTH),
    .ADDR_W(ADDR_W)
  ) u_hot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (hot_cmd),
    .del_idx_i (hot_del_idx),
    .ins_addr_i(wr_addr_i),
    .wr_addr_i (wr_addr_i),
    .qry_addr_i(qry_addr_i),
    .wr_hit_o  (hot_wr_hit),
    .wr_idx_o  (hot_wr_idx),
    .qry_hit_o (hot_qry_hit),
    .full_o    (hot_full),
    .lru_addr_o(hot_lru),
    .mru_vld_o (hot_mru_vld),
    .mru_addr_o(hot_mru)
  );

  hdi_lru_list #(
    .DEPTH (CAND_DEPTH),
    .ADDR_W(ADDR_W)
  ) u_cand (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cand_cmd),
    .del_idx_i (cand_del_idx),
    .ins_addr_i(cand_ins_addr),
    .wr_addr_i (wr_addr_i),
    .qry_addr_i(qry_addr_i),
    .wr_hit_o  (cand_wr_hit),
    .wr_idx_o  (cand_wr_idx),
    .qry_hit_o (cand_qry_hit),
    .full_o    (cand_full),
    .lru_addr_o(cand_lru),
    .mru_vld_o (cand_mru_vld),
    .mru_addr_o(cand_mru)
  );

  logic unused_cand;
  assign unused_cand = ^{cand_qry_hit, cand_full, cand_lru};

  // answer taken from pre-update state of the hot list
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qry_vld_q <= 1'b0;
      qry_hot_q <= 1'b0;
    end else begin
      qry_vld_q <= qry_valid_i;
      qry_hot_q <= qry_valid_i && hot_qry_hit;
    end
  end

  assign qry_vld_o = qry_vld_q;
  assign qry_hot_o = qry_hot_q;

  assert_lists_disjoint_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hot_wr_hit && cand_wr_hit));

  assert_promote_mru_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WR_CAND) |=> (hot_mru_vld && hot_mru == $past(wr_addr_i)));

  assert_refresh_mru_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WR_HOT) |=> (hot_mru_vld && hot_mru == $past(wr_addr_i)));

  assert_new_cand_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WR_NEW) |=> (cand_mru_vld && cand_mru == $past(wr_addr_i)));

  assert_demote_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WR_CAND && hot_full) |=> (hot_full && cand_mru_vld && cand_mru == $past(hot_lru)));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> ($stable(hot_mru) && $stable(cand_mru) && $stable(hot_lru) && $stable(hot_full)));

  assert_qry_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_valid_i |=> qry_vld_o);

  assert_qry_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qry_valid_i |=> (!qry_vld_o && !qry_hot_o));

endmodule

// File: tb/tb_hot_data_ident.sv
module tb_hot_data_ident;

  localparam int unsigned AW     = 32;
  localparam int unsigned HOT_N  = 4;
  localparam int unsigned CAND_N = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_valid_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic          qry_valid_i = 1'b0;
  logic [AW-1:0] qry_addr_i = '0;
  logic          qry_vld_o, qry_hot_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int            issue;
    logic          exp_hot;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [AW-1:0] hot_m[$];
  logic [AW-1:0] cand_m[$];
  logic [15:0]   lfsr = 16'hACE1;

  hot_data_ident #(.ADDR_W(AW), .HOT_DEPTH(HOT_N), .CAND_DEPTH(CAND_N)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .qry_valid_i(qry_valid_i),
    .qry_addr_i (qry_addr_i),
    .qry_vld_o  (qry_vld_o),
    .qry_hot_o  (qry_hot_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic model_hot(input logic [AW-1:0] a);
    foreach (hot_m[i]) if (hot_m[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_write(input logic [AW-1:0] a);
    int hi = -1;
    int ci = -1;
    foreach (hot_m[i]) if (hot_m[i] == a) hi = i;
    foreach (cand_m[i]) if (cand_m[i] == a) ci = i;
    if (hi >= 0) begin
      hot_m.delete(hi);
      hot_m.push_front(a);
    end else if (ci >= 0) begin
      cand_m.delete(ci);
      hot_m.push_front(a);
      if (hot_m.size() > HOT_N) cand_m.push_front(hot_m.pop_back());
    end else begin
      cand_m.push_front(a);
      if (cand_m.size() > CAND_N) void'(cand_m.pop_back());
    end
  endtask

  // driver: one cycle of stimulus, expected answers go to the scoreboard
  task automatic step(input logic we, input logic [AW-1:0] wa,
                      input logic qe, input logic [AW-1:0] qa, input string tag);
    exp_t e;
    @(negedge clk_i);
    wr_valid_i  = we;
    wr_addr_i   = wa;
    qry_valid_i = qe;
    qry_addr_i  = qa;
    if (qe) begin
      e.issue   = cyc;
      e.exp_hot = model_hot(qa);
      e.addr    = qa;
      e.tag     = tag;
      sb_q.push_back(e);
    end
    if (we) model_write(wa);
  endtask

  task automatic wr(input logic [AW-1:0] a);
    step(1'b1, a, 1'b0, '0, "");
  endtask

  task automatic qry(input logic [AW-1:0] a, input string tag);
    step(1'b0, '0, 1'b1, a, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, "");
  endtask

  task automatic do_reset();
    idle(3);
    @(negedge clk_i);
    rst_ni = 1'b0;
    hot_m.delete();
    cand_m.delete();
    @(negedge clk_i);
    checks++;
    if (qry_vld_o !== 1'b0 || qry_hot_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset: actual vld=%b hot=%b expected vld=0 hot=0",
               qry_vld_o, qry_hot_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor: pops expectations when the design answers
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sb_q.size() > 0 && sb_q[0].issue == cyc - 1) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (qry_vld_o !== 1'b1) begin
          errors++;
          $display("FAIL R8 answer missing for addr %h: actual vld=%b expected 1", e.addr, qry_vld_o);
        end else if (qry_hot_o !== e.exp_hot) begin
          errors++;
          $display("FAIL %s addr %h: actual hot=%b expected %b", e.tag, e.addr, qry_hot_o, e.exp_hot);
        end
      end else begin
        checks++;
        if (qry_vld_o !== 1'b0) begin
          errors++;
          $display("FAIL R8 unexpected answer: actual vld=%b expected 0", qry_vld_o);
        end
      end
    end
  end

  task automatic run_all();
    do_reset();
    // R1: empty after reset
    qry(32'h0, "R1");
    qry(32'h10, "R1");
    // R9: writes without valid are ignored
    step(1'b0, 32'h10, 1'b0, '0, "");
    step(1'b0, 32'h10, 1'b0, '0, "");
    qry(32'h10, "R9");
    // R2: first write only makes a candidate
    wr(32'h10);
    qry(32'h10, "R2");
    // R3: second write promotes
    wr(32'h10);
    qry(32'h10, "R3");
    // R7: same-cycle query sees state before the write
    wr(32'h20);
    step(1'b1, 32'h20, 1'b1, 32'h20, "R7");
    qry(32'h20, "R7");
    // fill hot list: 40,30,20,10
    wr(32'h30); wr(32'h30);
    wr(32'h40); wr(32'h40);
    // R4: refresh 10, promote 50 -> 20 is the one pushed out
    wr(32'h10);
    wr(32'h50); wr(32'h50);
    qry(32'h20, "R4");
    qry(32'h10, "R4");
    qry(32'h50, "R4");
    // R5: demoted 20 survives 7 new candidates and returns with one write
    for (int i = 0; i < 7; i++) wr(32'h100 + i);
    qry(32'h20, "R5");
    wr(32'h20);
    qry(32'h20, "R5");
    qry(32'h30, "R5");
    // R6: candidate list full, a new insert drops the oldest (100)
    wr(32'h200);
    wr(32'h100);
    qry(32'h100, "R6");
    wr(32'h101);
    qry(32'h101, "R6");
    wr(32'h102);
    qry(32'h102, "R6");

    // R10: promotion with a non-full hot list leaves a free candidate slot
    do_reset();
    qry(32'h10, "R1");
    for (int i = 0; i < 8; i++) wr(32'h300 + i);
    wr(32'h302);
    wr(32'h308);
    wr(32'h300);
    qry(32'h300, "R10");
    wr(32'h309);
    wr(32'h301);
    qry(32'h301, "R10");

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] wa, qa;
      logic we, qe;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wa = 32'h1000 + AW'(lfsr[4:0] % 20);
      qa = 32'h1000 + AW'(lfsr[12:8] % 20);
      we = lfsr[5] | lfsr[14];
      qe = lfsr[7] | lfsr[6];
      step(we, wa, qe, qa, "R3 mixed");
    end
    idle(4);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R8 unanswered queries: actual %0d expected 0", sb_q.size());
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule